// File: doc/BRIEF.md
# Three-Wire Serial Memory Slave

This block is the device side of a three-wire serial memory with a chip select. A host selects it, clocks in a start bit, a two-bit opcode, an address and, for programming commands, a data word. The block then reads from, writes to or erases a small byte array. The serial clock and data lines are sampled in the system clock domain. A synchroniser and a rising-edge detector feed a framing state machine, so the host clock may stall at any level for any length of time.

Word width is chosen at run time. With the organisation input high the array behaves as 16-bit words; with it low it behaves as bytes. Each 16-bit word is the pair of bytes at addresses 2w and 2w+1, with the even byte in the upper half. Programming is allowed only when the write-enable latch is set and the program-enable input is high. A self-timed busy period follows every accepted program, measured in system clocks. That period finishes even if chip select drops. While chip select is high, the data output reports whether the part is ready.

Top module: `mw_eeprom_slave`

## Requirements
- R1: After reset, do_o is low and the write-enable latch is clear, so a programming command sent before any enable is refused.
- R2: While chip select is low, the framing logic is held idle and do_o is low. An instruction cut short by chip select falling has no effect.
- R3: While chip select is high, rising serial-clock edges with DI low before the first DI-high edge are ignored. That first DI-high edge is taken as the start bit.
- R4: The two bits after the start bit are the opcode: 10 read, 01 write, 11 erase. Opcode 00 is an extended command chosen by the top two address bits: 11 enable, 00 disable, 10 erase all, 01 write all. The address follows MSB first, with BYTE_AW bits in byte mode and BYTE_AW-1 bits in word mode. A data word of 8 or 16 bits then follows, MSB first.
- R5: After the edge carrying the last address bit of a read, do_o shows one 0 bit. Each following rising edge then presents the next data bit, MSB first.
- R6: While chip select stays high, a read keeps streaming words at successive addresses. The address wraps from the top of the array to 0.
- R7: In word mode, word w holds byte 2w in bits 15:8 and byte 2w+1 in bits 7:0.
- R8: Write stores the data word. Erase sets one word to all ones. Erase-all sets every byte to all ones. Write-all stores the data word in every word.
- R9: Programming is refused unless the enable command has set the write-enable latch. The disable command clears the latch.
- R10: While pe_i is low, every write and erase command is refused and leaves the array unchanged.
- R11: After an accepted program command, and while chip select is high, do_o is low while busy and high once ready. It stays high until the next start bit. A refused command shows no status, and no start bit is taken while busy.
- R12: A program cycle runs to completion even when chip select falls during it. Including any array walk, it lasts at most 2^(BYTE_AW-1)+BUSY_CYCLES+2 system clocks.
- R13: Once an instruction has received all its bits, further serial clocks and DI values are ignored until chip select falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock from host |
| di_i | input | 1 | Serial data in |
| org_i | input | 1 | Organisation: 1 = 16-bit words, 0 = bytes |
| pe_i | input | 1 | Program enable, high permits write and erase |
| do_o | output | 1 | Serial data out / ready-busy status |

## Verification
Faults in the framing counter or the opcode decode show up first as a misaligned read. Such a fault shifts or corrupts the very next word streamed on do_o, within one word time of the last address bit. A wrong write-enable latch or a wrong program-enable gate shows up at once on do_o: the busy-low indication appears where none should, or is missing where it should appear, a dozen system clocks after the final bit. A fault in the array walk or the byte-lane mapping stays hidden until a later read in the other organisation, or at the wrapped address, returns a byte that differs from the shadow model.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    FS_IDLE, FS_HDR, FS_DATA, FS_READ, FS_DONE
  } fsm_state_t;

  typedef enum logic [1:0] {
    PG_IDLE, PG_WALK, PG_WAIT
  } pgm_state_t;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] EXT_DIS  = 2'b00;
  localparam logic [1:0] EXT_WALL = 2'b01;
  localparam logic [1:0] EXT_EALL = 2'b10;
  localparam logic [1:0] EXT_EN   = 2'b11;
endpackage

// File: rtl/mw_edge_sync.sv
module mw_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_i,
  input  logic sclk_i,
  input  logic di_i,
  output logic cs_s,
  output logic di_s,
  output logic sclk_rise
);
  logic [STAGES-1:0] cs_q, ck_q, di_q;
  logic ck_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q    <= '0;
      ck_q    <= '0;
      di_q    <= '0;
      ck_prev <= 1'b0;
    end else begin
      cs_q    <= {cs_q[STAGES-2:0], cs_i};
      ck_q    <= {ck_q[STAGES-2:0], sclk_i};
      di_q    <= {di_q[STAGES-2:0], di_i};
      ck_prev <= ck_q[STAGES-1];
    end
  end

  assign cs_s      = cs_q[STAGES-1];
  assign di_s      = di_q[STAGES-1];
  assign sclk_rise = ck_q[STAGES-1] & ~ck_prev;
endmodule

// File: rtl/mw_word_store.sv
module mw_word_store #(
  parameter int IDXW = 7
) (
  input  logic            clk,
  input  logic [1:0]      we,
  input  logic [IDXW-1:0] widx,
  input  logic [15:0]     wd,
  input  logic [IDXW-1:0] ridx,
  output logic [15:0]     rd
);
  localparam int DEPTH = 1 << IDXW;

  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic [7:0] mem [DEPTH];
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (we[g]) mem[widx] <= wd[g*8 +: 8];
      q <= mem[ridx];
    end
    assign rd[g*8 +: 8] = q;
  end
endmodule

// File: rtl/mw_frame_fsm.sv
module mw_frame_fsm
  import mw_pkg::*;
#(
  parameter int BYTE_AW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_s,
  input  logic               di_s,
  input  logic               rise,
  input  logic               org,
  input  logic               busy,
  input  logic               show,
  input  logic [15:0]        rd,
  output logic [BYTE_AW-2:0] ridx,
  output logic               req_v,
  output logic               req_all,
  output logic [BYTE_AW-1:0] req_addr,
  output logic [15:0]        req_data,
  output logic               wen_set,
  output logic               wen_clr,
  output logic               start_p,
  output fsm_state_t         state_o,
  output logic               do_o
);
  localparam int CNTW = $clog2(BYTE_AW + 18);

  fsm_state_t         state;
  logic [CNTW-1:0]    cnt;
  logic [1:0]         op;
  logic [BYTE_AW-1:0] addr;
  logic [15:0]        dat, sh;
  logic               rbit, do_q;

  logic [CNTW-1:0]    hdr_last, wlast;
  logic [BYTE_AW-1:0] amask, a_full;
  logic [1:0]         top2;
  logic [15:0]        aligned;
  logic [7:0]         even_b, odd_b;

  assign hdr_last = org ? CNTW'(BYTE_AW) : CNTW'(BYTE_AW + 1);
  assign wlast    = org ? CNTW'(15) : CNTW'(7);
  assign amask    = org ? {1'b0, {(BYTE_AW-1){1'b1}}} : {BYTE_AW{1'b1}};
  assign a_full   = {addr[BYTE_AW-2:0], di_s};
  assign top2     = org ? a_full[BYTE_AW-2 -: 2] : a_full[BYTE_AW-1 -: 2];
  assign even_b   = rd[7:0];
  assign odd_b    = rd[15:8];
  assign aligned  = org ? {even_b, odd_b} : {(addr[0] ? odd_b : even_b), 8'h00};
  assign ridx     = org ? addr[BYTE_AW-2:0] : addr[BYTE_AW-1:1];

  always_ff @(posedge clk) begin
    req_v   <= 1'b0;
    wen_set <= 1'b0;
    wen_clr <= 1'b0;
    start_p <= 1'b0;
    if (rst || !cs_s) begin
      state    <= FS_IDLE;
      cnt      <= '0;
      op       <= '0;
      addr     <= '0;
      dat      <= '0;
      sh       <= '0;
      rbit     <= 1'b0;
      req_all  <= 1'b0;
      req_addr <= '0;
      req_data <= '0;
    end else if (rise) begin
      unique case (state)
        FS_IDLE: if (di_s && !busy) begin
          state   <= FS_HDR;
          cnt     <= '0;
          op      <= '0;
          addr    <= '0;
          start_p <= 1'b1;
        end
        FS_HDR: begin
          cnt <= cnt + CNTW'(1);
          if (cnt < CNTW'(2)) op <= {op[0], di_s};
          else addr <= a_full;
          if (cnt == hdr_last) begin
            cnt <= '0;
            dat <= '0;
            unique case (op)
              OP_READ: begin
                state <= FS_READ;
                rbit  <= 1'b0;
                addr  <= a_full & amask;
              end
              OP_WRITE: state <= FS_DATA;
              OP_ERASE: begin
                state    <= FS_DONE;
                req_v    <= 1'b1;
                req_all  <= 1'b0;
                req_addr <= a_full & amask;
                req_data <= 16'hFFFF;
              end
              default: begin
                state <= (top2 == EXT_WALL) ? FS_DATA : FS_DONE;
                wen_set <= (top2 == EXT_EN);
                wen_clr <= (top2 == EXT_DIS);
                if (top2 == EXT_EALL) begin
                  req_v    <= 1'b1;
                  req_all  <= 1'b1;
                  req_data <= 16'hFFFF;
                end
              end
            endcase
          end
        end
        FS_DATA: begin
          dat <= {dat[14:0], di_s};
          cnt <= cnt + CNTW'(1);
          if (cnt == wlast) begin
            state    <= FS_DONE;
            req_v    <= 1'b1;
            req_all  <= (op == OP_EXT);
            req_addr <= addr & amask;
            req_data <= {dat[14:0], di_s};
          end
        end
        FS_READ: begin
          if (cnt == '0) begin
            rbit <= aligned[15];
            sh   <= aligned << 1;
            cnt  <= wlast;
          end else begin
            rbit <= sh[15];
            sh   <= sh << 1;
            cnt  <= cnt - CNTW'(1);
            if (cnt == CNTW'(1)) addr <= (addr + BYTE_AW'(1)) & amask;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !cs_s)          do_q <= 1'b0;
    else if (state == FS_READ) do_q <= rbit;
    else if (show)             do_q <= ~busy;
    else                       do_q <= 1'b0;
  end

  assign do_o    = do_q;
  assign state_o = state;
endmodule

// File: rtl/mw_prog_engine.sv
module mw_prog_engine
  import mw_pkg::*;
#(
  parameter int BYTE_AW     = 8,
  parameter int BUSY_CYCLES = 200
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_v,
  input  logic               req_all,
  input  logic [BYTE_AW-1:0] req_addr,
  input  logic [15:0]        req_data,
  input  logic               wen_set,
  input  logic               wen_clr,
  input  logic               start_p,
  input  logic               pe,
  input  logic               org,
  output logic               busy,
  output logic               show,
  output logic [1:0]         we,
  output logic [BYTE_AW-2:0] widx,
  output logic [15:0]        wd
);
  localparam int IDXW = BYTE_AW - 1;
  localparam int BW   = $clog2(BUSY_CYCLES + 1);

  pgm_state_t      st;
  logic            wen, p_all, p_org, p_bsel;
  logic [IDXW-1:0] p_idx;
  logic [15:0]     p_data;
  logic [BW-1:0]   wcnt;
  logic            accept;

  assign accept = req_v && wen && pe && (st == PG_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= PG_IDLE;
      wen    <= 1'b0;
      show   <= 1'b0;
      p_all  <= 1'b0;
      p_org  <= 1'b0;
      p_bsel <= 1'b0;
      p_idx  <= '0;
      p_data <= '0;
      wcnt   <= '0;
    end else begin
      if (wen_set)      wen <= 1'b1;
      else if (wen_clr) wen <= 1'b0;
      if (accept)       show <= 1'b1;
      else if (start_p) show <= 1'b0;
      unique case (st)
        PG_IDLE: if (accept) begin
          st     <= PG_WALK;
          p_all  <= req_all;
          p_org  <= org;
          p_bsel <= req_addr[0];
          p_data <= req_data;
          p_idx  <= req_all ? '0 : (org ? req_addr[IDXW-1:0] : req_addr[BYTE_AW-1:1]);
        end
        PG_WALK: begin
          if (!p_all || (&p_idx)) begin
            st   <= PG_WAIT;
            wcnt <= '0;
          end else begin
            p_idx <= p_idx + IDXW'(1);
          end
        end
        default: begin
          wcnt <= wcnt + BW'(1);
          if (wcnt == BW'(BUSY_CYCLES - 1)) st <= PG_IDLE;
        end
      endcase
    end
  end

  assign busy = (st != PG_IDLE);
  assign widx = p_idx;
  assign we   = (st != PG_WALK) ? 2'b00 :
                (p_all || p_org) ? 2'b11 :
                (p_bsel ? 2'b10 : 2'b01);
  assign wd   = {p_data[7:0], (p_org ? p_data[15:8] : p_data[7:0])};
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
  import mw_pkg::*;
#(
  parameter int BYTE_AW     = 8,
  parameter int BUSY_CYCLES = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_i,
  input  logic sclk_i,
  input  logic di_i,
  input  logic org_i,
  input  logic pe_i,
  output logic do_o
);
  localparam int IDXW = BYTE_AW - 1;

  logic               cs_s, di_s, rise;
  logic               busy, show;
  logic               req_v, req_all, wen_set, wen_clr, start_p;
  logic [BYTE_AW-1:0] req_addr;
  logic [15:0]        req_data, rd, wd;
  logic [IDXW-1:0]    ridx, widx;
  logic [1:0]         we;
  fsm_state_t         fsm_st;

  mw_edge_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .cs_i(cs_i), .sclk_i(sclk_i), .di_i(di_i),
    .cs_s(cs_s), .di_s(di_s), .sclk_rise(rise)
  );

  mw_frame_fsm #(.BYTE_AW(BYTE_AW)) u_fsm (
    .clk(clk), .rst(rst), .cs_s(cs_s), .di_s(di_s), .rise(rise),
    .org(org_i), .busy(busy), .show(show), .rd(rd), .ridx(ridx),
    .req_v(req_v), .req_all(req_all), .req_addr(req_addr),
    .req_data(req_data), .wen_set(wen_set), .wen_clr(wen_clr),
    .start_p(start_p), .state_o(fsm_st), .do_o(do_o)
  );

  mw_prog_engine #(.BYTE_AW(BYTE_AW), .BUSY_CYCLES(BUSY_CYCLES)) u_pgm (
    .clk(clk), .rst(rst), .req_v(req_v), .req_all(req_all),
    .req_addr(req_addr), .req_data(req_data), .wen_set(wen_set),
    .wen_clr(wen_clr), .start_p(start_p), .pe(pe_i), .org(org_i),
    .busy(busy), .show(show), .we(we), .widx(widx), .wd(wd)
  );

  mw_word_store #(.IDXW(IDXW)) u_store (
    .clk(clk), .we(we), .widx(widx), .wd(wd), .ridx(ridx), .rd(rd)
  );
endmodule

// File: rtl/mw_eeprom_checks.sv
module mw_eeprom_checks
  import mw_pkg::*;
#(
  parameter int BYTE_AW     = 8,
  parameter int BUSY_CYCLES = 200
) (
  input logic       clk,
  input logic       rst,
  input logic       cs_s,
  input logic       pe_i,
  input logic       busy,
  input fsm_state_t fsm_st,
  input logic       do_o
);
  localparam int LIMIT = (1 << (BYTE_AW - 1)) + BUSY_CYCLES + 2;
  localparam int RW    = $clog2(LIMIT + 2);

  logic [RW-1:0] busy_run;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_run <= '0;
    else if (busy_run != {RW{1'b1}}) busy_run <= busy_run + RW'(1);
  end

  assert_deselect_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !cs_s |=> !do_o);

  assert_pe_gate_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(pe_i));

  assert_no_decode_busy_R11: assert property (@(posedge clk) disable iff (rst)
    busy |-> (fsm_st == FS_IDLE || fsm_st == FS_DONE));

  assert_busy_bound_R12: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_run <= RW'(LIMIT)));
endmodule

bind mw_eeprom_slave mw_eeprom_checks #(
  .BYTE_AW(BYTE_AW), .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .cs_s(cs_s), .pe_i(pe_i),
  .busy(busy), .fsm_st(fsm_st), .do_o(do_o)
);

// File: tb/tb_mw_eeprom_slave.sv
module tb_mw_eeprom_slave;
  localparam int BAW  = 8;
  localparam int BUSY = 40;
  localparam int NB   = 1 << BAW;

  logic clk = 1'b0, rst = 1'b1;
  logic cs = 1'b0, sclk = 1'b0, di = 1'b0, org = 1'b0, pe = 1'b1;
  logic do_o;

  int n_vec = 0, n_bad = 0;
  logic [7:0] model [NB];

  typedef struct { logic [15:0] v; int w; string tag; } exp_t;
  exp_t exp_q[$];
  event samp;

  mw_eeprom_slave #(.BYTE_AW(BAW), .BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rst(rst), .cs_i(cs), .sclk_i(sclk), .di_i(di),
    .org_i(org), .pe_i(pe), .do_o(do_o)
  );

  always #5 clk = ~clk;

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  // scoreboard monitor: collects DO bits, compares against queued words
  initial begin
    logic [15:0] acc;
    int n;
    acc = '0; n = 0;
    forever begin
      @(samp);
      if (exp_q.size() == 0) begin
        chk("R5 unexpected read bit", 16'd1, 16'd0);
      end else begin
        acc = {acc[14:0], do_o};
        n++;
        if (n == exp_q[0].w) begin
          chk(exp_q[0].tag, acc & ((exp_q[0].w == 16) ? 16'hFFFF : 16'h00FF), exp_q[0].v);
          void'(exp_q.pop_front());
          acc = '0; n = 0;
        end
      end
    end
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask
  task automatic clk_bit(logic b);
    di = b; tick(4); sclk = 1'b1; tick(8); sclk = 1'b0; tick(4);
  endtask
  task automatic sel(); cs = 1'b1; tick(4); endtask
  task automatic desel(); cs = 1'b0; di = 1'b0; tick(8); endtask

  function automatic int awid(); return org ? BAW - 1 : BAW; endfunction
  function automatic int ext(int code); return code << (awid() - 2); endfunction

  task automatic header(logic [1:0] op, int addr);
    for (int i = 0; i < 3; i++) clk_bit(1'b0);   // stray clocks (R3)
    clk_bit(1'b1);
    clk_bit(op[1]);
    clk_bit(op[0]);
    for (int i = awid() - 1; i >= 0; i--) clk_bit(addr[i]);
  endtask

  task automatic do_read(int addr, int nwords, string tag);
    int a, w, mask;
    exp_t e;
    w = org ? 16 : 8;
    mask = (1 << awid()) - 1;
    a = addr & mask;
    sel();
    header(2'b10, addr);
    chk({tag, " R5 dummy zero"}, {15'd0, do_o}, 16'd0);
    for (int k = 0; k < nwords; k++) begin
      e.v = org ? {model[2*a], model[2*a+1]} : {8'h00, model[a]};
      e.w = w;
      e.tag = tag;
      exp_q.push_back(e);
      a = (a + 1) & mask;
    end
    for (int i = 0; i < nwords * w; i++) begin
      clk_bit(1'b0);
      -> samp;
    end
    desel();
  endtask

  task automatic do_prog(logic [1:0] op, int addr, logic [15:0] data,
                         bit has_data, bit ok, string tag);
    int t;
    sel();
    header(op, addr);
    if (has_data)
      for (int i = (org ? 15 : 7); i >= 0; i--) clk_bit(data[i]);
    tick(4);
    if (ok) begin
      chk({tag, " R11 busy low"}, {15'd0, do_o}, 16'd0);
      t = 0;
      while (do_o !== 1'b1 && t < 800) begin tick(1); t++; end
      chk({tag, " R11 ready high"}, {15'd0, do_o}, 16'd1);
      clk_bit(1'b1); clk_bit(1'b1); clk_bit(1'b0);
      chk({tag, " R13 trailing clocks ignored"}, {15'd0, do_o}, 16'd1);
    end else begin
      tick(100);
      chk({tag, " no status"}, {15'd0, do_o}, 16'd0);
    end
    desel();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int t;
    for (int i = 0; i < NB; i++) model[i] = 8'hxx;
    tick(5);
    rst = 1'b0;
    tick(3);
    chk("R1 reset do_o", {15'd0, do_o}, 16'd0);

    // latch clear after reset: erase-all refused
    do_prog(2'b00, ext(2), 16'h0, 0, 0, "R1 erase-all before enable");
    do_prog(2'b00, ext(3), 16'h0, 0, 0, "R9 enable cmd");
    do_prog(2'b00, ext(2), 16'h0, 0, 1, "R4 R8 erase-all");
    for (int i = 0; i < NB; i++) model[i] = 8'hFF;
    do_read(0, 4, "R8 erased bytes");

    do_prog(2'b01, 5, 16'h00A5, 1, 1, "R8 write byte5");
    model[5] = 8'hA5;
    do_read(4, 3, "R6 sequential bytes");

    do_prog(2'b01, 255, 16'h005A, 1, 1, "R8 write byte255");
    model[255] = 8'h5A;
    do_read(255, 2, "R6 byte wrap");

    org = 1'b1;
    do_prog(2'b01, 10, 16'h1234, 1, 1, "R8 write word10");
    model[20] = 8'h12; model[21] = 8'h34;
    do_read(10, 1, "R5 word read");
    do_read(2, 1, "R7 word from bytes");
    do_read(127, 2, "R6 word wrap");
    org = 1'b0;
    do_read(20, 2, "R7 bytes of word");

    org = 1'b1;
    pe = 1'b0;
    do_prog(2'b01, 10, 16'hBEEF, 1, 0, "R10 write with pe low");
    do_prog(2'b00, ext(2), 16'h0, 0, 0, "R10 erase-all with pe low");
    pe = 1'b1;
    do_read(10, 1, "R10 word unchanged");
    org = 1'b0;

    do_prog(2'b00, ext(0), 16'h0, 0, 0, "R9 disable cmd");
    do_prog(2'b01, 3, 16'h0011, 1, 0, "R9 write while disabled");
    do_read(3, 1, "R9 byte unchanged");
    do_prog(2'b00, ext(3), 16'h0, 0, 0, "R9 re-enable");

    do_prog(2'b11, 5, 16'h0, 0, 1, "R8 erase byte5");
    model[5] = 8'hFF;
    do_read(5, 1, "R8 erased byte5");

    do_prog(2'b00, ext(1), 16'h003C, 1, 1, "R8 write-all bytes");
    for (int i = 0; i < NB; i++) model[i] = 8'h3C;
    do_read(0, 3, "R8 write-all bytes read");
    do_read(250, 1, "R8 write-all high byte");

    org = 1'b1;
    do_prog(2'b00, ext(1), 16'hC3E1, 1, 1, "R8 write-all words");
    for (int i = 0; i < NB; i += 2) begin model[i] = 8'hC3; model[i+1] = 8'hE1; end
    org = 1'b0;
    do_read(0, 2, "R7 R8 write-all word lanes");

    // chip select falls during the program cycle
    sel();
    header(2'b11, 7);
    desel();
    sel();
    chk("R12 busy after cs drop", {15'd0, do_o}, 16'd0);
    t = 0;
    while (do_o !== 1'b1 && t < 800) begin tick(1); t++; end
    chk("R12 cycle completes", {15'd0, do_o}, 16'd1);
    desel();
    model[7] = 8'hFF;
    do_read(7, 1, "R12 byte7 erased");

    // instruction cut short by chip select
    sel();
    header(2'b01, 9);
    for (int i = 0; i < 4; i++) clk_bit(1'b0);
    desel();
    chk("R2 do_o low deselected", {15'd0, do_o}, 16'd0);
    do_read(9, 1, "R2 aborted write no effect");

    // long run of stray clocks before the start bit
    sel();
    for (int i = 0; i < 12; i++) clk_bit(1'b0);
    desel();
    do_read(6, 1, "R3 stray clocks then read");

    tick(20);
    if (exp_q.size() != 0) chk("R5 pending reads", 16'(exp_q.size()), 16'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule